// File: doc/BRIEF.md
# Multi-Queue Ring Pointer Manager

This block keeps the producer side of several software-owned circular queues that live in system memory. Each queue has a base address, a ring length in bytes, a consumer offset that software writes, a producer offset that the block advances, and a fill threshold. Records are 16 bytes wide and arrive one at a time with a queue index. For each record the block decides to write it, hold the producer back, or discard it, following that queue's full policy.

Each accepted record leaves as a single write request that carries the memory address and the record. Two header bits are rewritten on the way: the epoch (phase) bit and the lost-entry flag. The memory transaction itself happens outside the block, which waits for a done strobe before it takes the next record. Single-cycle pulses report discarded records, stalls on a full queue, threshold crossings and overlapping enabled rings. A debug streaming mode sends every record to the queue base and leaves the ring pointers alone.

Top module: `ringq_mgr`

## Requirements
- R1: A written record goes to address base + tail. After the write, the tail steps by 16 and returns to 0 when it would reach the ring size. Tail and head are byte offsets from the base. Record bits other than 31 and 29 pass through unchanged.
- R2: Record bit 31 carries the queue's epoch bit. The epoch bit is 1 after reset and inverts every time the tail wraps back to offset 0.
- R3: A record whose queue enable bit is clear, or whose index is not below the queue count, is accepted and discarded. `err_disabled` pulses for one cycle and the tail is unchanged.
- R4: A queue is full when (tail + 16) mod size equals head. If the queue is full, its overwrite bit is clear and its stall bit is set, `in_ready` stays low and `err_full` pulses once per stall episode.
- R5: If a full queue has its overwrite bit set, the record is still written at the tail and the tail advances. Record bit 29 is set and no `err_full` pulse occurs. In every other write, bit 29 is 0.
- R6: If a full queue has both its overwrite bit and its stall bit clear, the record is discarded, `err_full` pulses once and the tail is unchanged.
- R7: Usage is (tail - head) mod size. While a queue's threshold enable is set and usage is at least its threshold, one `thr_irq` pulse fires and the `thr_passed` bit sets. Neither repeats until software writes that queue's head.
- R8: While `stream_mode` is high, every record goes to its queue's base address. The tail and epoch are unchanged, the queue never counts as full, and bit 29 is 0.
- R9: `err_overlap` pulses for one cycle when two or more enabled queues with nonzero size come to have intersecting address ranges [base, base+size).
- R10: Only one write is outstanding at a time. `wr_valid`, `wr_addr` and `wr_rec` hold steady until `wr_done`, and `in_ready` is low while a write is outstanding.
- R11: After reset, all tails and heads are 0, `wr_valid` is low, every pulse output is low and `thr_passed` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| q_en | input | NQ | Per-queue enable |
| bp_en | input | NQ | Per-queue stall-when-full policy |
| ovf_en | input | NQ | Per-queue overwrite-when-full policy |
| thr_en | input | NQ | Per-queue threshold interrupt enable |
| stream_mode | input | 1 | Debug mode: write to base, pointers frozen |
| cfg_base | input | NQ x AW | Ring base addresses |
| cfg_size | input | NQ x PW | Ring sizes in bytes (multiple of 16) |
| cfg_thr | input | NQ x PW | Usage thresholds in bytes |
| head_we | input | 1 | Head offset write strobe |
| head_idx | input | QIW | Queue selected by the head write |
| head_val | input | PW | New head offset |
| in_valid | input | 1 | Record present |
| in_ready | output | 1 | Record taken this cycle |
| in_qidx | input | QIW | Destination queue of the record |
| in_rec | input | 128 | Record body |
| wr_valid | output | 1 | Write request outstanding |
| wr_addr | output | AW | Write address |
| wr_rec | output | 128 | Record with header bits filled in |
| wr_done | input | 1 | Write completed |
| tail_out | output | NQ x PW | Current tail offsets |
| thr_passed | output | NQ | Sticky threshold-crossed flags |
| err_disabled | output | 1 | Pulse: record to a disabled queue discarded |
| err_full | output | 1 | Pulse: full queue stalled or discarded a record |
| err_overlap | output | 1 | Pulse: enabled rings overlap |
| thr_irq | output | NQ | Pulse: threshold reached |

## Verification
A wrong tail or epoch shows up on the very next write to that queue, as a wrong `wr_addr` or a wrong bit 31. It also shows one cycle after the write on `tail_out`. A wrong full decision shows in the cycle of the following push to that queue: `in_ready`, `err_full` or bit 29 differs from what the modelled pointers predict. A stuck or wrongly cleared threshold flag appears as an extra or missing `thr_irq` pulse, at most one cycle after usage changes or the head is written. The bench sweeps all four queues through several wraps under each full policy and checks every such port.

// File: rtl/ringq_pkg.sv
package ringq_pkg;
    localparam int REC_W     = 128;
    localparam int REC_BYTES = 16;
    localparam int PHASE_BIT = 31;
    localparam int LOST_BIT  = 29;

    typedef enum logic [1:0] {
        ACT_WRITE,
        ACT_STALL,
        ACT_DROP_DIS,
        ACT_DROP_FULL
    } act_e;
endpackage

// File: rtl/ringq_ptr.sv
module ringq_ptr #(
    parameter int PW = 16
) (
    input  logic [PW-1:0] tail,
    input  logic [PW-1:0] head,
    input  logic [PW-1:0] size,
    input  logic [PW-1:0] thr,
    output logic [PW-1:0] tail_nxt,
    output logic          wrap,
    output logic          full,
    output logic          over_thr
);
    logic [PW:0] step;
    logic [PW:0] used;

    always_comb begin
        step     = {1'b0, tail} + (PW+1)'(ringq_pkg::REC_BYTES);
        wrap     = step >= {1'b0, size};
        tail_nxt = wrap ? '0 : step[PW-1:0];
        full     = (tail_nxt == head);
        if (tail >= head) used = {1'b0, tail} - {1'b0, head};
        else              used = {1'b0, tail} + {1'b0, size} - {1'b0, head};
        over_thr = used[PW-1:0] >= thr;
    end
endmodule

// File: rtl/ringq_overlap.sv
module ringq_overlap #(
    parameter int NQ = 10,
    parameter int AW = 32,
    parameter int PW = 16
) (
    input  logic [NQ-1:0]         en,
    input  logic [NQ-1:0][AW-1:0] base,
    input  logic [NQ-1:0][PW-1:0] size,
    output logic                  hit
);
    logic [NQ-1:0][AW:0] lo;
    logic [NQ-1:0][AW:0] hi;

    always_comb begin
        for (int i = 0; i < NQ; i++) begin
            lo[i] = {1'b0, base[i]};
            hi[i] = {1'b0, base[i]} + {{(AW+1-PW){1'b0}}, size[i]};
        end
        hit = 1'b0;
        for (int i = 0; i < NQ; i++) begin
            for (int j = i + 1; j < NQ; j++) begin
                if (en[i] && en[j] && (size[i] != '0) && (size[j] != '0) &&
                    (lo[i] < hi[j]) && (lo[j] < hi[i]))
                    hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ringq_mgr.sv
module ringq_mgr import ringq_pkg::*; #(
    parameter int NQ = 10,
    parameter int AW = 32,
    parameter int PW = 16,
    localparam int QIW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NQ-1:0]         q_en,
    input  logic [NQ-1:0]         bp_en,
    input  logic [NQ-1:0]         ovf_en,
    input  logic [NQ-1:0]         thr_en,
    input  logic                  stream_mode,
    input  logic [NQ-1:0][AW-1:0] cfg_base,
    input  logic [NQ-1:0][PW-1:0] cfg_size,
    input  logic [NQ-1:0][PW-1:0] cfg_thr,
    input  logic                  head_we,
    input  logic [QIW-1:0]        head_idx,
    input  logic [PW-1:0]         head_val,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [QIW-1:0]        in_qidx,
    input  logic [REC_W-1:0]      in_rec,
    output logic                  wr_valid,
    output logic [AW-1:0]         wr_addr,
    output logic [REC_W-1:0]      wr_rec,
    input  logic                  wr_done,
    output logic [NQ-1:0][PW-1:0] tail_out,
    output logic [NQ-1:0]         thr_passed,
    output logic                  err_disabled,
    output logic                  err_full,
    output logic                  err_overlap,
    output logic [NQ-1:0]         thr_irq
);
    typedef struct packed {
        logic [NQ-1:0][PW-1:0] tail;
        logic [NQ-1:0][PW-1:0] head;
        logic [NQ-1:0]         phase;
        logic [NQ-1:0]         passed;
        logic [NQ-1:0]         thr_irq;
        logic                  busy;
        logic                  stalled;
        logic                  ovl_prev;
        logic                  err_dis;
        logic                  err_full;
        logic                  err_ovl;
        logic [AW-1:0]         addr;
        logic [REC_W-1:0]      rec;
    } st_t;

    st_t s_q, s_d;

    logic [NQ-1:0][PW-1:0] tail_nxt;
    logic [NQ-1:0]         wrap, full, over_thr;
    logic                  ovl_hit;

    for (genvar g = 0; g < NQ; g++) begin : g_ptr
        ringq_ptr #(.PW(PW)) u_ptr (
            .tail     (s_q.tail[g]),
            .head     (s_q.head[g]),
            .size     (cfg_size[g]),
            .thr      (cfg_thr[g]),
            .tail_nxt (tail_nxt[g]),
            .wrap     (wrap[g]),
            .full     (full[g]),
            .over_thr (over_thr[g])
        );
    end

    ringq_overlap #(.NQ(NQ), .AW(AW), .PW(PW)) u_ovl (
        .en   (q_en),
        .base (cfg_base),
        .size (cfg_size),
        .hit  (ovl_hit)
    );

    logic           q_ok;
    logic [QIW-1:0] qs;
    logic           full_sel;
    act_e           act;

    always_comb begin
        q_ok     = {1'b0, in_qidx} < (QIW+1)'(NQ);
        qs       = q_ok ? in_qidx : '0;
        full_sel = full[qs] && !stream_mode;
        if (!q_ok || !q_en[qs])            act = ACT_DROP_DIS;
        else if (full_sel && !ovf_en[qs])  act = bp_en[qs] ? ACT_STALL : ACT_DROP_FULL;
        else                               act = ACT_WRITE;
        in_ready = !s_q.busy && (act != ACT_STALL);
    end

    always_comb begin
        s_d          = s_q;
        s_d.err_dis  = 1'b0;
        s_d.err_full = 1'b0;
        s_d.thr_irq  = '0;

        if (s_q.busy && wr_done) s_d.busy = 1'b0;

        s_d.stalled = in_valid && !s_q.busy && (act == ACT_STALL);
        if (s_d.stalled && !s_q.stalled) s_d.err_full = 1'b1;

        if (in_valid && in_ready) begin
            unique case (act)
                ACT_DROP_DIS:  s_d.err_dis  = 1'b1;
                ACT_DROP_FULL: s_d.err_full = 1'b1;
                ACT_WRITE: begin
                    s_d.busy                = 1'b1;
                    s_d.rec                 = in_rec;
                    s_d.rec[PHASE_BIT]      = s_q.phase[qs];
                    s_d.rec[LOST_BIT]       = full_sel;
                    s_d.addr                = cfg_base[qs] +
                        (stream_mode ? '0 : {{(AW-PW){1'b0}}, s_q.tail[qs]});
                    if (!stream_mode) begin
                        s_d.tail[qs] = tail_nxt[qs];
                        if (wrap[qs]) s_d.phase[qs] = ~s_q.phase[qs];
                    end
                end
                default: ;
            endcase
        end

        for (int i = 0; i < NQ; i++) begin
            if (head_we && (head_idx == QIW'(i))) begin
                s_d.head[i]   = head_val;
                s_d.passed[i] = 1'b0;
            end else if (thr_en[i] && !s_q.passed[i] && over_thr[i]) begin
                s_d.thr_irq[i] = 1'b1;
                s_d.passed[i]  = 1'b1;
            end
        end

        s_d.ovl_prev = ovl_hit;
        s_d.err_ovl  = ovl_hit && !s_q.ovl_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_valid     = s_q.busy;
    assign wr_addr      = s_q.addr;
    assign wr_rec       = s_q.rec;
    assign tail_out     = s_q.tail;
    assign thr_passed   = s_q.passed;
    assign err_disabled = s_q.err_dis;
    assign err_full     = s_q.err_full;
    assign err_overlap  = s_q.err_ovl;
    assign thr_irq      = s_q.thr_irq;

    // R10: request held steady until completion
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_done) |=> (wr_valid && $stable(wr_addr) && $stable(wr_rec)));

    // R10: no new record taken while a write is outstanding
    a_r10_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !in_ready);

    // R3: record taken for a disabled queue never becomes a write
    a_r3_drop_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !q_en[qs]) |=> (err_disabled && !wr_valid));

    // R9: overlap report is a single-cycle pulse
    a_r9_ovl_single: assert property (@(posedge clk) disable iff (!rst_n)
        err_overlap |=> !err_overlap);

    for (genvar g = 0; g < NQ; g++) begin : g_chk
        // R7: threshold pulse never repeats back to back
        a_r7_thr_once: assert property (@(posedge clk) disable iff (!rst_n)
            thr_irq[g] |=> !thr_irq[g]);
        // R7: pulse leaves the sticky flag set
        a_r7_thr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            thr_irq[g] |-> thr_passed[g]);
    end
endmodule

// File: tb/ringq_mgr_tb.sv
module ringq_mgr_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NQ = 4;
    localparam int AW = 16;
    localparam int PW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NQ-1:0] q_en = '0, bp_en = '0, ovf_en = '0, thr_en = '0;
    logic stream_mode = 1'b0;
    logic [NQ-1:0][AW-1:0] cfg_base;
    logic [NQ-1:0][PW-1:0] cfg_size, cfg_thr;
    logic head_we = 1'b0;
    logic [1:0] head_idx = '0;
    logic [PW-1:0] head_val = '0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [1:0] in_qidx = '0;
    logic [127:0] in_rec = '0;
    logic wr_valid;
    logic [AW-1:0] wr_addr;
    logic [127:0] wr_rec;
    logic wr_done = 1'b0;
    logic [NQ-1:0][PW-1:0] tail_out;
    logic [NQ-1:0] thr_passed, thr_irq;
    logic err_disabled, err_full, err_overlap;

    always #(CLK_PERIOD/2) clk = ~clk;

    ringq_mgr #(.NQ(NQ), .AW(AW), .PW(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .q_en(q_en), .bp_en(bp_en), .ovf_en(ovf_en),
        .thr_en(thr_en), .stream_mode(stream_mode), .cfg_base(cfg_base),
        .cfg_size(cfg_size), .cfg_thr(cfg_thr), .head_we(head_we),
        .head_idx(head_idx), .head_val(head_val), .in_valid(in_valid),
        .in_ready(in_ready), .in_qidx(in_qidx), .in_rec(in_rec),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_rec(wr_rec),
        .wr_done(wr_done), .tail_out(tail_out), .thr_passed(thr_passed),
        .err_disabled(err_disabled), .err_full(err_full),
        .err_overlap(err_overlap), .thr_irq(thr_irq)
    );

    int tests = 0, fails = 0;
    int m_tail[NQ], m_head[NQ];
    logic m_phase[NQ];
    int thr_cnt[NQ];
    int ovl_cnt = 0;
    bit done = 0;

    always @(negedge clk) if (rst_n) begin
        for (int i = 0; i < NQ; i++) if (thr_irq[i]) thr_cnt[i]++;
        if (err_overlap) ovl_cnt++;
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int nxt(int q);
        return (m_tail[q] + 16 >= int'(cfg_size[q])) ? 0 : m_tail[q] + 16;
    endfunction

    task automatic set_head(int q, int v);
        @(negedge clk);
        head_we = 1'b1; head_idx = 2'(q); head_val = PW'(v);
        @(posedge clk); @(negedge clk);
        head_we = 1'b0;
        m_head[q] = v;
    endtask

    task automatic push(int q, logic [127:0] d);
        bit full, dis, stall, dropf;
        logic [127:0] er;
        full  = !stream_mode && (nxt(q) == m_head[q]);
        dis   = !q_en[q];
        stall = !dis && full && !ovf_en[q] && bp_en[q];
        dropf = !dis && full && !ovf_en[q] && !bp_en[q];
        in_qidx = 2'(q); in_rec = d; in_valid = 1'b1;
        #1;
        if (stall) begin
            chk(in_ready == 1'b0, "R4 ready", 128'(in_ready), 0);
            @(posedge clk); @(negedge clk);
            chk(err_full == 1'b1, "R4 pulse", 128'(err_full), 1);
            @(posedge clk); @(negedge clk);
            chk(err_full == 1'b0 && in_ready == 1'b0, "R4 once", 128'(err_full), 0);
            in_valid = 1'b0;
        end else begin
            chk(in_ready == 1'b1, "R10 ready", 128'(in_ready), 1);
            @(posedge clk); @(negedge clk);
            in_valid = 1'b0;
            if (dis) begin
                chk(err_disabled && !wr_valid, "R3", 128'({err_disabled, wr_valid}), 128'h2);
            end else if (dropf) begin
                chk(err_full && !wr_valid, "R6", 128'({err_full, wr_valid}), 128'h2);
            end else begin
                er = d; er[31] = m_phase[q]; er[29] = full;
                chk(wr_valid && !err_full, "R5 no err", 128'({wr_valid, err_full}), 128'h2);
                chk(wr_addr == cfg_base[q] + AW'(stream_mode ? 0 : m_tail[q]), "R1 R8 addr",
                    128'(wr_addr), 128'(cfg_base[q] + AW'(stream_mode ? 0 : m_tail[q])));
                chk(wr_rec == er, "R2 R5 rec", wr_rec, er);
                if (!stream_mode) begin
                    if (nxt(q) == 0) m_phase[q] = ~m_phase[q];
                    m_tail[q] = nxt(q);
                end
                @(posedge clk); @(negedge clk);
                chk(wr_valid && !in_ready, "R10 hold", 128'({wr_valid, in_ready}), 128'h2);
                wr_done = 1'b1;
                @(posedge clk); @(negedge clk);
                wr_done = 1'b0;
                chk(!wr_valid, "R10 done", 128'(wr_valid), 0);
            end
        end
        chk(int'(tail_out[q]) == m_tail[q], "R1 tail", 128'(tail_out[q]), 128'(m_tail[q]));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NQ; i++) begin
            m_tail[i] = 0; m_head[i] = 0; m_phase[i] = 1'b1; thr_cnt[i] = 0;
            cfg_base[i] = AW'(16'h100 * (i + 1));
            cfg_thr[i]  = '0;
        end
        cfg_size[0] = 64; cfg_size[1] = 48; cfg_size[2] = 64; cfg_size[3] = 32;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!wr_valid && tail_out == '0 && thr_passed == '0, "R11 state",
            128'({wr_valid, tail_out, thr_passed}), 0);
        chk(!err_full && !err_disabled && !err_overlap && thr_irq == '0, "R11 pulses",
            128'({err_full, err_disabled, err_overlap, thr_irq}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 disabled queue
        push(0, 128'h11);
        push(2, 128'h22);
        q_en = '1;
        // R1 R2 R6 sweep: fill, discard when full, drain, wrap
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < 5; k++)
                for (int q = 0; q < NQ; q++)
                    push(q, {32'(r), 32'(k), 32'(q), 32'hA5A5_0F0F});
            for (int q = 0; q < NQ; q++) set_head(q, m_tail[q]);
        end
        // R5 overwrite on queue 1
        ovf_en[1] = 1'b1;
        for (int k = 0; k < 5; k++) push(1, {96'h0, 32'hFFFF_FFFF});
        ovf_en[1] = 1'b0;
        set_head(1, m_tail[1]);
        // R4 stall on queue 2
        bp_en[2] = 1'b1;
        for (int k = 0; k < 4; k++) push(2, 128'h5555);
        set_head(2, m_tail[2]);
        push(2, 128'h6666);
        bp_en[2] = 1'b0;
        // R7 threshold on queue 3 (size 32, threshold 16)
        set_head(3, m_tail[3]);
        cfg_thr[3] = 16; thr_en[3] = 1'b1;
        repeat (2) @(negedge clk);
        chk(thr_cnt[3] == 0, "R7 idle", 128'(thr_cnt[3]), 0);
        push(3, 128'h77);
        repeat (2) @(negedge clk);
        chk(thr_cnt[3] == 1 && thr_passed[3], "R7 fire", 128'(thr_cnt[3]), 1);
        push(3, 128'h78);
        repeat (3) @(negedge clk);
        chk(thr_cnt[3] == 1, "R7 sticky", 128'(thr_cnt[3]), 1);
        set_head(3, m_tail[3]);
        @(negedge clk);
        chk(!thr_passed[3] && thr_cnt[3] == 1, "R7 rearm", 128'(thr_passed[3]), 0);
        push(3, 128'h79);
        repeat (2) @(negedge clk);
        chk(thr_cnt[3] == 2, "R7 again", 128'(thr_cnt[3]), 2);
        thr_en[3] = 1'b0;
        // R8 stream mode
        stream_mode = 1'b1;
        push(0, 128'h88);
        push(0, 128'h89);
        stream_mode = 1'b0;
        // R9 overlap
        chk(ovl_cnt == 0, "R9 none", 128'(ovl_cnt), 0);
        cfg_base[1] = 16'h0120;
        repeat (4) @(negedge clk);
        chk(ovl_cnt == 1, "R9 once", 128'(ovl_cnt), 1);
        q_en[1] = 1'b0;
        repeat (2) @(negedge clk);
        q_en[1] = 1'b1;
        repeat (3) @(negedge clk);
        chk(ovl_cnt == 2, "R9 again", 128'(ovl_cnt), 2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule